// File: doc/BRIEF.md
# LIN-Capable UART Status Flag and Interrupt Controller

This block holds the status flags of a UART that also handles LIN framing and turns them into two interrupt requests. The receiver, the transmitter and the synch-break detector each send one-cycle event strobes. The block records them as receive-full, overrun, framing-error, parity-error, break-detected and transmit-empty flags. The CPU side does not pass a bus into the block. It passes decoded access strobes: a receive-data read, a transmit-data write, a write to the clear-error control bit, a write to the break flag, a break-generation request and a write to the enable bits.

Each flag has its own way to clear. Receive-full clears on a data read. The three error flags clear together on a write of 1 to the clear-error bit. The break flag clears on a write of 0. Transmit-empty clears on a data write or on a break-generation request. A 2-bit mode input decides which error events may set a flag, and the allowed modes are parameter masks. A run-time option, which a parameter can remove, makes an accepted break also flush the receive-side flags.

Top module: `lin_uart_irq_ctrl`

## Requirements
- R1: After reset, tx_empty_o is 1. Every other flag, every enable output, rx_irq_o and tx_irq_o are 0.
- R2: rx_full_o is 1 in the cycle after ev_rx_load_i. It is 0 in the cycle after rd_rxdata_i, unless a set event occurs in the same cycle.
- R3: ev_overrun_i sets overrun_o in every mode. A clr_err_wr_i with clr_err_bit_i=1 clears overrun_o, framing_o and parity_o together. With clr_err_bit_i=0 it changes nothing. clr_err_rd_o always reads 0.
- R4: ev_parity_i sets parity_o only when mode_i is 2'b00.
- R5: ev_framing_i sets framing_o when mode_i is 2'b00 or 2'b01, and when mode_i is 2'b10 with sync_ss_i=1. It never sets framing_o when mode_i is 2'b11.
- R6: ev_break_i sets brk_det_o only when mode_i is 2'b11. A brk_flag_wr_i with brk_flag_bit_i=0 clears brk_det_o. With brk_flag_bit_i=1 it changes nothing.
- R7: ev_tx_xfer_i sets tx_empty_o. Either wr_txdata_i or brk_gen_req_i clears it.
- R8: When a set event and a clear strobe for the same flag occur in the same cycle, the flag is 1 in the next cycle.
- R9: When brk_clr_rx_i=1, a break accepted under R6 clears rx_full_o, overrun_o, framing_o and parity_o. A flag that has its own set event in the same cycle stays set.
- R10: rx_irq_o = ((rx_full_o | overrun_o | framing_o | parity_o) & rx_ie_o) | (brk_det_o & brk_ie_o).
- R11: tx_irq_o = tx_empty_o & tx_ie_o.
- R12: en_wr_i loads en_wdata_i into the enables: bit 0 is rx_ie_o, bit 1 is tx_ie_o, bit 2 is brk_ie_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| mode_i | input | 2 | operating mode |
| sync_ss_i | input | 1 | synchronous start/stop option |
| brk_clr_rx_i | input | 1 | break flushes the receive flags |
| ev_rx_load_i | input | 1 | received character loaded |
| ev_overrun_i | input | 1 | overrun event |
| ev_framing_i | input | 1 | framing error event |
| ev_parity_i | input | 1 | parity error event |
| ev_break_i | input | 1 | synch break detected |
| ev_tx_xfer_i | input | 1 | transmit data moved to the shifter |
| rd_rxdata_i | input | 1 | CPU reads the receive data |
| wr_txdata_i | input | 1 | CPU writes transmit data |
| clr_err_wr_i | input | 1 | write to the clear-error bit |
| clr_err_bit_i | input | 1 | value written to the clear-error bit |
| brk_flag_wr_i | input | 1 | write to the break flag |
| brk_flag_bit_i | input | 1 | value written to the break flag |
| brk_gen_req_i | input | 1 | break-generation bit set to 1 |
| en_wr_i | input | 1 | write to the enable bits |
| en_wdata_i | input | 3 | enable data {brk, tx, rx} |
| rx_full_o | output | 1 | receive-full flag |
| overrun_o | output | 1 | overrun flag |
| framing_o | output | 1 | framing error flag |
| parity_o | output | 1 | parity error flag |
| brk_det_o | output | 1 | break-detected flag |
| tx_empty_o | output | 1 | transmit-empty flag |
| rx_ie_o | output | 1 | receive interrupt enable |
| tx_ie_o | output | 1 | transmit interrupt enable |
| brk_ie_o | output | 1 | break interrupt enable |
| clr_err_rd_o | output | 1 | clear-error bit read-back value |
| rx_irq_o | output | 1 | receive interrupt request |
| tx_irq_o | output | 1 | transmit interrupt request |

## Verification
Every flag and enable is a single register. Its new value appears at the first clock edge after the strobe, and both interrupt outputs follow from those registers in the same cycle with no further delay. The bench drives each stimulus on the falling edge and holds it for exactly one cycle. It then waits for the next rising edge and samples one time unit after it, so every check reads the value due one edge after its stimulus. Set-wins collisions, mode-gated events and the break flush are each driven as single-cycle vectors. The outputs are compared in that same post-edge window.

// File: rtl/lin_irq_pkg.sv
package lin_irq_pkg;
   localparam int NUM_ERR = 3;
   localparam int ERR_OVR = 0;
   localparam int ERR_FRM = 1;
   localparam int ERR_PAR = 2;
   localparam int EN_RX   = 0;
   localparam int EN_TX   = 1;
   localparam int EN_BRK  = 2;
   localparam int NUM_EN  = 3;
endpackage

// File: rtl/lin_flag_cell.sv
module lin_flag_cell #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R8: the set event wins over a same-cycle clear
   a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/lin_rx_flags.sv
module lin_rx_flags
   import lin_irq_pkg::*;
#(
   parameter int MODE_W = 2,
   parameter logic [(1<<MODE_W)-1:0] PAR_MASK    = '0,
   parameter logic [(1<<MODE_W)-1:0] FRM_MASK    = '0,
   parameter logic [(1<<MODE_W)-1:0] FRM_SS_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [MODE_W-1:0]  mode_i,
   input  logic               sync_ss_i,
   input  logic               rx_load_i,
   input  logic [NUM_ERR-1:0] err_ev_i,
   input  logic               data_rd_i,
   input  logic               clr_err_i,
   input  logic               flush_i,
   output logic               rx_full_o,
   output logic [NUM_ERR-1:0] err_o
);
   logic [NUM_ERR-1:0] err_ok;
   logic [NUM_ERR-1:0] err_set;

   always_comb begin
      err_ok          = '0;
      err_ok[ERR_OVR] = 1'b1;
      err_ok[ERR_FRM] = FRM_MASK[mode_i] | (FRM_SS_MASK[mode_i] & sync_ss_i);
      err_ok[ERR_PAR] = PAR_MASK[mode_i];
   end

   assign err_set = err_ev_i & err_ok;

   lin_flag_cell #(.RST_VAL(1'b0)) u_full (
      .clk(clk), .rst_n(rst_n),
      .set_i(rx_load_i), .clr_i(data_rd_i | flush_i), .q_o(rx_full_o));

   for (genvar gi = 0; gi < NUM_ERR; gi++) begin : g_err
      lin_flag_cell #(.RST_VAL(1'b0)) u_err (
         .clk(clk), .rst_n(rst_n),
         .set_i(err_set[gi]), .clr_i(clr_err_i | flush_i), .q_o(err_o[gi]));
   end

   a_r2_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rx_load_i |=> rx_full_o);
   a_r4_parity_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (!PAR_MASK[mode_i] && !err_o[ERR_PAR]) |=> !err_o[ERR_PAR]);
   a_r5_framing_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (!FRM_MASK[mode_i] && !(FRM_SS_MASK[mode_i] && sync_ss_i) && !err_o[ERR_FRM])
      |=> !err_o[ERR_FRM]);
   a_r3_errors_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_err_i && err_ev_i == '0) |=> (err_o == '0));
   a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_i && !rx_load_i && err_ev_i == '0) |=> (!rx_full_o && err_o == '0));
endmodule

// File: rtl/lin_brk_tx_flags.sv
module lin_brk_tx_flags #(
   parameter int MODE_W = 2,
   parameter logic [(1<<MODE_W)-1:0] BRK_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              brk_ev_i,
   input  logic              brk_wr_i,
   input  logic              brk_bit_i,
   input  logic              tx_xfer_i,
   input  logic              tx_wr_i,
   input  logic              brk_gen_i,
   output logic              brk_hit_o,
   output logic              brk_det_o,
   output logic              tx_empty_o
);
   assign brk_hit_o = brk_ev_i & BRK_MASK[mode_i];

   lin_flag_cell #(.RST_VAL(1'b0)) u_brk (
      .clk(clk), .rst_n(rst_n),
      .set_i(brk_hit_o), .clr_i(brk_wr_i & ~brk_bit_i), .q_o(brk_det_o));

   lin_flag_cell #(.RST_VAL(1'b1)) u_txe (
      .clk(clk), .rst_n(rst_n),
      .set_i(tx_xfer_i), .clr_i(tx_wr_i | brk_gen_i), .q_o(tx_empty_o));

   a_r6_write_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_wr_i && brk_bit_i && !brk_ev_i) |=> $stable(brk_det_o));
   a_r6_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!BRK_MASK[mode_i] && !brk_det_o) |=> !brk_det_o);
   a_r7_txe_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_wr_i || brk_gen_i) && !tx_xfer_i) |=> !tx_empty_o);
endmodule

// File: rtl/lin_irq_combine.sv
module lin_irq_combine
   import lin_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr_i,
   input  logic [NUM_EN-1:0]  en_wdata_i,
   input  logic               rx_full_i,
   input  logic [NUM_ERR-1:0] err_i,
   input  logic               brk_det_i,
   input  logic               tx_empty_i,
   output logic [NUM_EN-1:0]  en_o,
   output logic               rx_irq_o,
   output logic               tx_irq_o
);
   logic rx_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       en_o <= '0;
      else if (en_wr_i) en_o <= en_wdata_i;
   end

   assign rx_any   = rx_full_i | (|err_i);
   assign rx_irq_o = (rx_any & en_o[EN_RX]) | (brk_det_i & en_o[EN_BRK]);
   assign tx_irq_o = tx_empty_i & en_o[EN_TX];

   a_r12_en_load: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr_i |=> (en_o == $past(en_wdata_i)));
   a_r12_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en_wr_i |=> $stable(en_o));
endmodule

// File: rtl/lin_uart_irq_ctrl.sv
module lin_uart_irq_ctrl
   import lin_irq_pkg::*;
#(
   parameter int MODE_W = 2,
   parameter logic [(1<<MODE_W)-1:0] PAR_MODE_MASK    = 4'b0001,
   parameter logic [(1<<MODE_W)-1:0] FRM_MODE_MASK    = 4'b0011,
   parameter logic [(1<<MODE_W)-1:0] FRM_SS_MODE_MASK = 4'b0100,
   parameter logic [(1<<MODE_W)-1:0] BRK_MODE_MASK    = 4'b1000,
   parameter bit BRK_FLUSH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              sync_ss_i,
   input  logic              brk_clr_rx_i,
   input  logic              ev_rx_load_i,
   input  logic              ev_overrun_i,
   input  logic              ev_framing_i,
   input  logic              ev_parity_i,
   input  logic              ev_break_i,
   input  logic              ev_tx_xfer_i,
   input  logic              rd_rxdata_i,
   input  logic              wr_txdata_i,
   input  logic              clr_err_wr_i,
   input  logic              clr_err_bit_i,
   input  logic              brk_flag_wr_i,
   input  logic              brk_flag_bit_i,
   input  logic              brk_gen_req_i,
   input  logic              en_wr_i,
   input  logic [2:0]        en_wdata_i,
   output logic              rx_full_o,
   output logic              overrun_o,
   output logic              framing_o,
   output logic              parity_o,
   output logic              brk_det_o,
   output logic              tx_empty_o,
   output logic              rx_ie_o,
   output logic              tx_ie_o,
   output logic              brk_ie_o,
   output logic              clr_err_rd_o,
   output logic              rx_irq_o,
   output logic              tx_irq_o
);
   localparam int NMODE = 1 << MODE_W;

   initial begin
      assert (MODE_W >= 1 && MODE_W <= 4)
         else $error("MODE_W out of range");
      assert ((FRM_MODE_MASK & FRM_SS_MODE_MASK) == '0)
         else $error("framing masks overlap");
      assert (NMODE == $bits(BRK_MODE_MASK))
         else $error("mask width mismatch");
   end

   logic [NUM_ERR-1:0] err_ev;
   logic [NUM_ERR-1:0] err_q;
   logic [NUM_EN-1:0]  en_q;
   logic               brk_hit;
   logic               flush;

   always_comb begin
      err_ev          = '0;
      err_ev[ERR_OVR] = ev_overrun_i;
      err_ev[ERR_FRM] = ev_framing_i;
      err_ev[ERR_PAR] = ev_parity_i;
   end

   if (BRK_FLUSH_EN) begin : g_flush
      assign flush = brk_hit & brk_clr_rx_i;
   end else begin : g_noflush
      logic unused_opt;
      assign unused_opt = brk_clr_rx_i;
      assign flush      = 1'b0;
   end

   lin_rx_flags #(
      .MODE_W(MODE_W), .PAR_MASK(PAR_MODE_MASK),
      .FRM_MASK(FRM_MODE_MASK), .FRM_SS_MASK(FRM_SS_MODE_MASK)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sync_ss_i(sync_ss_i),
      .rx_load_i(ev_rx_load_i), .err_ev_i(err_ev), .data_rd_i(rd_rxdata_i),
      .clr_err_i(clr_err_wr_i & clr_err_bit_i), .flush_i(flush),
      .rx_full_o(rx_full_o), .err_o(err_q));

   lin_brk_tx_flags #(.MODE_W(MODE_W), .BRK_MASK(BRK_MODE_MASK)) u_bt (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .brk_ev_i(ev_break_i), .brk_wr_i(brk_flag_wr_i), .brk_bit_i(brk_flag_bit_i),
      .tx_xfer_i(ev_tx_xfer_i), .tx_wr_i(wr_txdata_i), .brk_gen_i(brk_gen_req_i),
      .brk_hit_o(brk_hit), .brk_det_o(brk_det_o), .tx_empty_o(tx_empty_o));

   lin_irq_combine u_irq (
      .clk(clk), .rst_n(rst_n), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
      .rx_full_i(rx_full_o), .err_i(err_q), .brk_det_i(brk_det_o),
      .tx_empty_i(tx_empty_o), .en_o(en_q), .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o));

   assign overrun_o    = err_q[ERR_OVR];
   assign framing_o    = err_q[ERR_FRM];
   assign parity_o     = err_q[ERR_PAR];
   assign rx_ie_o      = en_q[EN_RX];
   assign tx_ie_o      = en_q[EN_TX];
   assign brk_ie_o     = en_q[EN_BRK];
   assign clr_err_rd_o = 1'b0;

   a_r11_tx_request: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tx_xfer_i && tx_ie_o && !en_wr_i) |=> tx_irq_o);
   a_r10_rx_request: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_rx_load_i && rx_ie_o && !en_wr_i) |=> rx_irq_o);
   a_r10_brk_request: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_hit && brk_ie_o && !en_wr_i) |=> rx_irq_o);
endmodule

// File: tb/lin_uart_irq_ctrl_tb.sv
`timescale 1ns/100ps
module lin_uart_irq_ctrl_tb;
   // ev  = {brk, txx, par, frm, ovr, rxl}
   // acc = {enwr, bgen, bfbit, bfwr, clrbit, clrwr, wrtx, rd}
   // exp = {rx_irq, tx_irq, txe, brk, par, frm, ovr, rxf}
   typedef struct packed {
      logic [3:0] req;
      logic [1:0] mode;
      logic       ss;
      logic       bclr;
      logic [5:0] ev;
      logic [7:0] acc;
      logic [2:0] en;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VEC [NV] = '{
      '{4'd12, 2'd0, 1'b0, 1'b0, 6'b000000, 8'b10000000, 3'b111, 8'b01100000},
      '{4'd7,  2'd0, 1'b0, 1'b0, 6'b000000, 8'b00000010, 3'b000, 8'b00000000},
      '{4'd7,  2'd0, 1'b0, 1'b0, 6'b010000, 8'b00000000, 3'b000, 8'b01100000},
      '{4'd7,  2'd0, 1'b0, 1'b0, 6'b000000, 8'b01000000, 3'b000, 8'b00000000},
      '{4'd2,  2'd0, 1'b0, 1'b0, 6'b000001, 8'b00000000, 3'b000, 8'b10000001},
      '{4'd2,  2'd0, 1'b0, 1'b0, 6'b000000, 8'b00000001, 3'b000, 8'b00000000},
      '{4'd8,  2'd0, 1'b0, 1'b0, 6'b000001, 8'b00000001, 3'b000, 8'b10000001},
      '{4'd2,  2'd0, 1'b0, 1'b0, 6'b000000, 8'b00000001, 3'b000, 8'b00000000},
      '{4'd4,  2'd0, 1'b0, 1'b0, 6'b001000, 8'b00000000, 3'b000, 8'b10001000},
      '{4'd3,  2'd0, 1'b0, 1'b0, 6'b000000, 8'b00000100, 3'b000, 8'b10001000},
      '{4'd3,  2'd0, 1'b0, 1'b0, 6'b000000, 8'b00001100, 3'b000, 8'b00000000},
      '{4'd4,  2'd1, 1'b0, 1'b0, 6'b001000, 8'b00000000, 3'b000, 8'b00000000},
      '{4'd5,  2'd1, 1'b0, 1'b0, 6'b000100, 8'b00000000, 3'b000, 8'b10000100},
      '{4'd3,  2'd2, 1'b0, 1'b0, 6'b000010, 8'b00000000, 3'b000, 8'b10000110},
      '{4'd3,  2'd2, 1'b0, 1'b0, 6'b000000, 8'b00001100, 3'b000, 8'b00000000},
      '{4'd5,  2'd2, 1'b0, 1'b0, 6'b000100, 8'b00000000, 3'b000, 8'b00000000},
      '{4'd5,  2'd2, 1'b1, 1'b0, 6'b000100, 8'b00000000, 3'b000, 8'b10000100},
      '{4'd3,  2'd2, 1'b1, 1'b0, 6'b000000, 8'b00001100, 3'b000, 8'b00000000},
      '{4'd5,  2'd3, 1'b1, 1'b0, 6'b000100, 8'b00000000, 3'b000, 8'b00000000},
      '{4'd6,  2'd0, 1'b0, 1'b0, 6'b100000, 8'b00000000, 3'b000, 8'b00000000},
      '{4'd6,  2'd3, 1'b0, 1'b0, 6'b100000, 8'b00000000, 3'b000, 8'b10010000},
      '{4'd6,  2'd3, 1'b0, 1'b0, 6'b000000, 8'b00110000, 3'b000, 8'b10010000},
      '{4'd6,  2'd3, 1'b0, 1'b0, 6'b000000, 8'b00010000, 3'b000, 8'b00000000},
      '{4'd10, 2'd3, 1'b0, 1'b0, 6'b000000, 8'b10000000, 3'b001, 8'b00000000},
      '{4'd10, 2'd3, 1'b0, 1'b0, 6'b100000, 8'b00000000, 3'b000, 8'b00010000},
      '{4'd10, 2'd3, 1'b0, 1'b0, 6'b000001, 8'b00000000, 3'b000, 8'b10010001},
      '{4'd3,  2'd3, 1'b0, 1'b0, 6'b000010, 8'b00000000, 3'b000, 8'b10010011},
      '{4'd9,  2'd3, 1'b0, 1'b1, 6'b100000, 8'b00000000, 3'b000, 8'b00010000},
      '{4'd9,  2'd3, 1'b0, 1'b1, 6'b100001, 8'b00000000, 3'b000, 8'b10010001},
      '{4'd11, 2'd3, 1'b0, 1'b0, 6'b010000, 8'b00000000, 3'b000, 8'b10110001},
      '{4'd6,  2'd3, 1'b0, 1'b0, 6'b000000, 8'b00010000, 3'b000, 8'b10100001},
      '{4'd8,  2'd3, 1'b0, 1'b0, 6'b100000, 8'b00010000, 3'b000, 8'b10110001},
      '{4'd11, 2'd3, 1'b0, 1'b0, 6'b000000, 8'b10000000, 3'b010, 8'b01110001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] mode_i;
   logic sync_ss_i, brk_clr_rx_i;
   logic ev_rx_load_i, ev_overrun_i, ev_framing_i, ev_parity_i, ev_break_i, ev_tx_xfer_i;
   logic rd_rxdata_i, wr_txdata_i, clr_err_wr_i, clr_err_bit_i;
   logic brk_flag_wr_i, brk_flag_bit_i, brk_gen_req_i, en_wr_i;
   logic [2:0] en_wdata_i;
   logic rx_full_o, overrun_o, framing_o, parity_o, brk_det_o, tx_empty_o;
   logic rx_ie_o, tx_ie_o, brk_ie_o, clr_err_rd_o, rx_irq_o, tx_irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   lin_uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sync_ss_i(sync_ss_i),
      .brk_clr_rx_i(brk_clr_rx_i), .ev_rx_load_i(ev_rx_load_i),
      .ev_overrun_i(ev_overrun_i), .ev_framing_i(ev_framing_i),
      .ev_parity_i(ev_parity_i), .ev_break_i(ev_break_i),
      .ev_tx_xfer_i(ev_tx_xfer_i), .rd_rxdata_i(rd_rxdata_i),
      .wr_txdata_i(wr_txdata_i), .clr_err_wr_i(clr_err_wr_i),
      .clr_err_bit_i(clr_err_bit_i), .brk_flag_wr_i(brk_flag_wr_i),
      .brk_flag_bit_i(brk_flag_bit_i), .brk_gen_req_i(brk_gen_req_i),
      .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
      .rx_full_o(rx_full_o), .overrun_o(overrun_o), .framing_o(framing_o),
      .parity_o(parity_o), .brk_det_o(brk_det_o), .tx_empty_o(tx_empty_o),
      .rx_ie_o(rx_ie_o), .tx_ie_o(tx_ie_o), .brk_ie_o(brk_ie_o),
      .clr_err_rd_o(clr_err_rd_o), .rx_irq_o(rx_irq_o), .tx_irq_o(tx_irq_o));

   function automatic logic [7:0] observed();
      return {rx_irq_o, tx_irq_o, tx_empty_o, brk_det_o, parity_o,
              framing_o, overrun_o, rx_full_o};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic idle();
      mode_i = 2'd0; sync_ss_i = 1'b0; brk_clr_rx_i = 1'b0;
      {ev_break_i, ev_tx_xfer_i, ev_parity_i, ev_framing_i, ev_overrun_i, ev_rx_load_i} = '0;
      {en_wr_i, brk_gen_req_i, brk_flag_bit_i, brk_flag_wr_i,
       clr_err_bit_i, clr_err_wr_i, wr_txdata_i, rd_rxdata_i} = '0;
      en_wdata_i = '0;
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      mode_i = v.mode; sync_ss_i = v.ss; brk_clr_rx_i = v.bclr;
      {ev_break_i, ev_tx_xfer_i, ev_parity_i, ev_framing_i, ev_overrun_i, ev_rx_load_i} = v.ev;
      {en_wr_i, brk_gen_req_i, brk_flag_bit_i, brk_flag_wr_i,
       clr_err_bit_i, clr_err_wr_i, wr_txdata_i, rd_rxdata_i} = v.acc;
      en_wdata_i = v.en;
      @(posedge clk);
      #1;
      idle();
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values
      check("R1 flags", {8'd0, observed()}, {8'd0, 8'b00100000});
      check("R1 enables", {13'd0, brk_ie_o, tx_ie_o, rx_ie_o}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i]);
         check($sformatf("R%0d vector %0d", VEC[i].req, i),
               {8'd0, observed()}, {8'd0, VEC[i].exp});
      end

      // R12: enable outputs after the last vector wrote 3'b010
      check("R12 enables", {13'd0, brk_ie_o, tx_ie_o, rx_ie_o}, 16'b010);
      // R3: clear-error bit always reads 0, also during a write of 1
      @(negedge clk);
      clr_err_wr_i = 1'b1; clr_err_bit_i = 1'b1;
      #1;
      check("R3 clear bit readback", {15'd0, clr_err_rd_o}, 16'd0);
      @(posedge clk); #1; idle();
      check("R3 readback after write", {15'd0, clr_err_rd_o}, 16'd0);
      // R10: rx irq from break with break enable only
      apply('{4'd10, 2'd0, 1'b0, 1'b0, 6'b000000, 8'b10000000, 3'b100, 8'b0});
      check("R10 brk enable irq", {15'd0, rx_irq_o}, {15'd0, brk_det_o});
      // R1: mid-run reset
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 async reset flags", {8'd0, observed()}, {8'd0, 8'b00100000});
      check("R1 async reset enables", {13'd0, brk_ie_o, tx_ie_o, rx_ie_o}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule